// File: doc/BRIEF.md
# Four-Channel Bus-Hold Arbiter with Pass-Through Channels

This block sits between four peripheral request lines and a single upstream hold handshake. When any request that is not masked arrives, the arbiter raises its upstream hold request. Once the upstream side answers with hold acknowledge, the arbiter asserts the acknowledge line of the one channel it selected. Channel 0 has the highest priority and channel 3 the lowest. The choice is made only while the bus is free, or in the cycle after the current owner lets go. A channel that holds the bus is never pre-empted.

Each channel runs in one of two modes. In ordinary mode, a per-channel address engine outside this block does the transfer: the arbiter raises `drive_en` so that the engine's address and strobe drivers are enabled, and the engine ends the grant with a pulse on `eng_done`. In pass-through mode the channel only receives its acknowledge and `drive_en` stays low. Whatever is attached to the channel does its own addressing. That can be a bus-mastering device, or the hold request of a second arbiter of this kind, with the channel's acknowledge wired back as that arbiter's hold acknowledge. A pass-through grant lasts until the attached requester drops its request. For this reason a channel wired to a downstream arbiter cannot also serve ordinary transfers.

Request inputs are asynchronous and pass through a two-stage synchronizer before they take part in arbitration. A per-channel mask removes a request from arbitration.

Top module: `dma_cascade_arb`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `hold_req_o`, `chan_ack` and `drive_en` are all 0.
- R2: A request on an idle arbiter raises `hold_req_o` on the third rising edge after it is applied. It is still low after the second edge.
- R3: `chan_ack` has at most one bit set. That bit (bit i is channel i) rises only on the edge after `hold_ack_i` was sampled high with `hold_req_o` high. It is never set while `hold_req_o` is low.
- R4: In an ordinary grant, `drive_en` is high together with the acknowledge. The grant ignores the channel's request going low, and it ends on the edge after a one-cycle `eng_done` pulse. `drive_en` is never high without an acknowledge.
- R5: Among eligible requests seen together, the lowest channel number wins.
- R6: The acknowledge does not move to another channel while a grant is running, even when a higher-priority request arrives.
- R7: A channel whose `chan_mask` bit is 1 never raises `hold_req_o` and is never granted. It does not block lower-priority channels.
- R8: When a grant ends, `chan_ack` is 0 for one cycle while `hold_req_o` stays high. If an eligible request is pending and `hold_ack_i` is still high, the next owner is acknowledged on the following edge. If no request is pending, `hold_req_o` falls on that edge.
- R9: A channel whose `chan_casc` bit is 1 is granted in pass-through mode. `drive_en` stays 0 for the whole grant.
- R10: A pass-through grant ignores `eng_done`. Its acknowledge falls on the third edge after the channel's request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Asynchronous per-channel request lines |
| chan_mask | input | NCH | 1 removes the channel from arbitration |
| chan_casc | input | NCH | 1 selects pass-through mode for the channel |
| eng_done | input | 1 | One-cycle pulse from the address engine that ends an ordinary grant |
| hold_ack_i | input | 1 | Upstream hold acknowledge |
| hold_req_o | output | 1 | Upstream hold request |
| chan_ack | output | NCH | One-hot per-channel acknowledge |
| drive_en | output | 1 | Enables the engine's address and strobe drivers during an ordinary grant |

## Verification
The bound checker tests on every cycle the properties that need no scenario: the acknowledge is one-hot, it appears only under a raised hold request and only after hold acknowledge, it is not pre-empted, `drive_en` needs an acknowledge, pass-through grants never drive, and reset clears the outputs. What only the bench scenarios can show is the exact latency through the synchronizer, which channel wins under fixed priority and masking, the one-cycle gap on handoff, and that a pass-through grant ignores the engine pulse and ends on the dropped request. The bench checks these through a scoreboard of expected grants and cycle-exact samples of the outputs.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2,
    ST_GAP  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sreq,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] casc,
  input  logic           eng_done,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [NCH-1:0] ack,
  output logic           drv
);
  arb_state_t     state_q, state_d;
  logic [NCH-1:0] owner_q, owner_d;
  logic           casc_q, casc_d;
  logic [NCH-1:0] elig, pick_oh;
  logic           pick_any, release_now;

  assign elig = sreq & ~mask;

  dma_prio_pick #(.W(NCH)) u_pick (
    .req  (elig),
    .pick (pick_oh),
    .any  (pick_any)
  );

  // pass-through owners leave when their request goes; ordinary owners on engine pulse
  assign release_now = casc_q ? ~|(sreq & owner_q) : eng_done;

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    casc_d  = casc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_any) begin
          state_d = ST_WAIT;
          owner_d = pick_oh;
          casc_d  = |(pick_oh & casc);
        end
      end
      ST_WAIT: begin
        if (hold_ack) state_d = ST_OWN;
      end
      ST_OWN: begin
        if (release_now) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (pick_any) begin
          owner_d = pick_oh;
          casc_d  = |(pick_oh & casc);
          state_d = hold_ack ? ST_OWN : ST_WAIT;
        end else begin
          state_d = ST_IDLE;
          owner_d = '0;
          casc_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      owner_q  <= '0;
      casc_q   <= 1'b0;
      hold_req <= 1'b0;
      ack      <= '0;
      drv      <= 1'b0;
    end else begin
      state_q  <= state_d;
      owner_q  <= owner_d;
      casc_q   <= casc_d;
      hold_req <= (state_d != ST_IDLE);
      ack      <= (state_d == ST_OWN) ? owner_d : '0;
      drv      <= (state_d == ST_OWN) && !casc_d;
    end
  end
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] chan_casc,
  input  logic           eng_done,
  input  logic           hold_ack_i,
  output logic           hold_req_o,
  output logic [NCH-1:0] chan_ack,
  output logic           drive_en
);
  logic [NCH-1:0] req_sync;

  dma_req_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (chan_req),
    .dout (req_sync)
  );

  dma_grant_fsm #(.NCH(NCH)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sreq     (req_sync),
    .mask     (chan_mask),
    .casc     (chan_casc),
    .eng_done (eng_done),
    .hold_ack (hold_ack_i),
    .hold_req (hold_req_o),
    .ack      (chan_ack),
    .drv      (drive_en)
  );
endmodule

// File: rtl/dma_cascade_arb_chk.sv
module dma_cascade_arb_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] chan_casc,
  input logic           hold_ack_i,
  input logic           hold_req_o,
  input logic [NCH-1:0] chan_ack,
  input logic           drive_en
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (chan_ack == '0 && !hold_req_o && !drive_en));

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_ack));

  assert_ack_under_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (chan_ack != '0) |-> hold_req_o);

  assert_ack_after_hold_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(|chan_ack) |-> ($past(hold_ack_i) && $past(hold_req_o)));

  assert_drive_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (chan_ack != '0));

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (rst)
    (chan_ack != '0) |=> (chan_ack == '0 || $stable(chan_ack)));

  assert_casc_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    ((chan_ack & chan_casc) != '0) |-> !drive_en);
endmodule

bind dma_cascade_arb dma_cascade_arb_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chan_casc  (chan_casc),
  .hold_ack_i (hold_ack_i),
  .hold_req_o (hold_req_o),
  .chan_ack   (chan_ack),
  .drive_en   (drive_en)
);

// File: tb/dma_cascade_arb_tb.sv
module dma_cascade_arb_tb;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chan_req  = '0;
  logic [NCH-1:0] chan_mask = '0;
  logic [NCH-1:0] chan_casc = '0;
  logic           eng_done  = 1'b0;
  logic           hold_ack_i = 1'b0;
  logic           hold_req_o;
  logic [NCH-1:0] chan_ack;
  logic           drive_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  dma_cascade_arb #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .chan_req(chan_req), .chan_mask(chan_mask),
    .chan_casc(chan_casc), .eng_done(eng_done), .hold_ack_i(hold_ack_i),
    .hold_req_o(hold_req_o), .chan_ack(chan_ack), .drive_en(drive_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // driver side of the scoreboard: the grant the requirements predict next
  task automatic expect_grant(input int ch, input bit casc);
    exp_q.push_back(ch * 2 + int'(casc));
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    step(1);
    eng_done = 1'b0;
  endtask

  // monitor: pops the expected grant whenever an acknowledge appears
  logic [NCH-1:0] prev_ack = '0;
  always @(negedge clk) begin
    if (!rst && chan_ack != '0 && prev_ack == '0) begin
      int idx;
      int got;
      int want;
      idx = -1;
      for (int i = 0; i < NCH; i++) if (chan_ack[i]) idx = i;
      got = idx * 2 + int'(!drive_en);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected grant", got, -1);
      end else begin
        want = exp_q.pop_front();
        check(got == want, "R5/R9 scoreboard grant channel*2+passthru", got, want);
      end
    end
    prev_ack = chan_ack;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3);
    // R1 reset state
    check(hold_req_o == 0 && chan_ack == 0 && drive_en == 0, "R1 reset outputs",
          {hold_req_o, chan_ack, drive_en}, 0);
    rst = 1'b0;
    step(1);
    check(hold_req_o == 0 && chan_ack == 0, "R1 after reset", {hold_req_o, chan_ack}, 0);

    // ordinary grant on channel 2
    chan_req = 4'b0100;
    step(2);
    check(hold_req_o == 0, "R2 hold low after two edges", hold_req_o, 0);
    step(1);
    check(hold_req_o == 1, "R2 hold high on third edge", hold_req_o, 1);
    step(2);
    check(chan_ack == 0, "R3 no ack without hold_ack", chan_ack, 0);
    expect_grant(2, 0);
    hold_ack_i = 1'b1;
    step(1);
    check(chan_ack == 4'b0100, "R3 ack after hold_ack", chan_ack, 4'b0100);
    check(drive_en == 1, "R4 drive with ordinary grant", drive_en, 1);
    chan_req = '0;
    step(3);
    check(chan_ack == 4'b0100, "R4 request drop ignored", chan_ack, 4'b0100);
    pulse_done();
    check(chan_ack == 0 && hold_req_o == 1, "R8 gap cycle", {hold_req_o, chan_ack}, 5'b10000);
    step(1);
    check(hold_req_o == 0, "R8 hold drops when nothing pending", hold_req_o, 0);
    hold_ack_i = 1'b0;

    // priority and no pre-emption
    chan_req = 4'b1010;
    step(3);
    check(hold_req_o == 1, "R2 hold for ch1/ch3", hold_req_o, 1);
    expect_grant(1, 0);
    hold_ack_i = 1'b1;
    step(1);
    check(chan_ack == 4'b0010, "R5 ch1 beats ch3", chan_ack, 4'b0010);
    chan_req = 4'b1011;
    step(4);
    check(chan_ack == 4'b0010, "R6 ch0 does not pre-empt", chan_ack, 4'b0010);
    expect_grant(0, 0);
    chan_req = 4'b1001;
    pulse_done();
    check(chan_ack == 0 && hold_req_o == 1, "R8 handoff gap", {hold_req_o, chan_ack}, 5'b10000);
    step(1);
    check(chan_ack == 4'b0001, "R8 ch0 granted after gap", chan_ack, 4'b0001);
    chan_req = 4'b1000;
    step(3);
    expect_grant(3, 0);
    pulse_done();
    step(1);
    check(chan_ack == 4'b1000, "R5 ch3 served last", chan_ack, 4'b1000);
    chan_req = '0;
    step(3);
    pulse_done();
    step(1);
    check(hold_req_o == 0, "R8 idle after last owner", hold_req_o, 0);
    hold_ack_i = 1'b0;

    // masking
    chan_mask = 4'b0001;
    chan_req  = 4'b0001;
    step(6);
    check(hold_req_o == 0, "R7 masked request ignored", hold_req_o, 0);
    chan_req = 4'b0101;
    step(3);
    check(hold_req_o == 1, "R7 unmasked ch2 requests", hold_req_o, 1);
    expect_grant(2, 0);
    hold_ack_i = 1'b1;
    step(1);
    check(chan_ack == 4'b0100, "R7 ch2 wins over masked ch0", chan_ack, 4'b0100);
    chan_req = '0;
    step(3);
    pulse_done();
    step(1);
    check(hold_req_o == 0, "R7 no grant to masked ch0", hold_req_o, 0);
    hold_ack_i = 1'b0;
    chan_mask = '0;

    // pass-through grant on channel 3
    chan_casc = 4'b1000;
    chan_req  = 4'b1000;
    step(3);
    expect_grant(3, 1);
    hold_ack_i = 1'b1;
    step(1);
    check(chan_ack == 4'b1000 && drive_en == 0, "R9 pass-through no drive",
          {chan_ack, drive_en}, 5'b10000);
    pulse_done();
    check(chan_ack == 4'b1000, "R10 eng_done ignored", chan_ack, 4'b1000);
    chan_req = '0;
    step(2);
    check(chan_ack == 4'b1000, "R10 ack held two edges after drop", chan_ack, 4'b1000);
    step(1);
    check(chan_ack == 0, "R10 ack falls on third edge", chan_ack, 0);
    step(1);
    check(hold_req_o == 0, "R8 hold released after pass-through", hold_req_o, 0);
    hold_ack_i = 1'b0;

    // pass-through owner hands over to an ordinary channel
    chan_req = 4'b1000;
    step(3);
    expect_grant(3, 1);
    hold_ack_i = 1'b1;
    step(1);
    chan_req = 4'b1010;
    step(2);
    expect_grant(1, 0);
    chan_req = 4'b0010;
    step(3);
    check(chan_ack == 0 && hold_req_o == 1, "R8 gap after pass-through", {hold_req_o, chan_ack}, 5'b10000);
    step(1);
    check(chan_ack == 4'b0010 && drive_en == 1, "R9 ordinary next owner drives",
          {chan_ack, drive_en}, 5'b00101);
    chan_req = '0;
    step(3);
    pulse_done();
    step(1);
    check(hold_req_o == 0, "R8 final release", hold_req_o, 0);
    hold_ack_i = 1'b0;
    step(2);

    check(exp_q.size() == 0, "R5 all expected grants seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule